// File: doc/BRIEF.md
# Restartable Vector Element Sequencer

This block walks a strided vector memory instruction through its elements, one element index at a time. It sends one address translation request per element and waits for the answer. The answer is either a hit or a page fault. On a hit the sequencer moves to the next element. On a fault it stops at once, raises a one-cycle trap with the index and address of the failing element, and returns to idle.

A single progress register ties the fault path to the restart path. On a trap it captures the failing element index. Every new instruction starts issuing at the index the register holds, so a re-executed instruction never revisits elements that were already translated. The register returns to zero only when an instruction finishes every element, which means the following instruction starts at element zero. A fault handler, including one that refills page tables in software, reads and writes the register through a small CSR port.

Element addresses are the base address plus the element index times the stride, modulo the address width. Moving data, chaining between instructions and the translation cache itself are outside this block.

Top module: `vec_restart_seq`

## Requirements
- R1: After reset, busy_o, done_o, trap_o and xlat_req_o are 0, and csr_rdata_o reads 0.
- R2: When start_i is sampled high while idle, the first request (if any) carries element index equal to the progress register value at that edge, with address base_i + index*stride_i.
- R3: Element i is requested at address base + i*stride, truncated to ADDR_W bits. Indices increase by exactly one from request to request.
- R4: At most one request is outstanding. xlat_req_o is high for a single cycle per element. The next request comes only after xlat_rsp_valid_i reports a hit (xlat_fault_i low) for the current element. Responses are taken no earlier than the cycle after the request.
- R5: A response with xlat_fault_i high makes trap_o pulse with trap_idx_o and trap_addr_o set to the failing element's index and address. The progress register takes that index, and no further request follows.
- R6: Starting again after a trap begins at the faulting element, and no index below it is requested.
- R7: When every element from the starting index up to vlen_i-1 hits, done_o pulses and the progress register reads 0, so the next instruction starts at element 0.
- R8: If the progress register is greater than or equal to vlen_i at start, no request is issued, done_o pulses one cycle after busy_o rises, and the register is cleared to 0.
- R9: A CSR write (csr_we_i) changes the progress register only while busy_o is low and start_i is low. csr_rdata_o always shows the register's current value.
- R10: busy_o rises in the cycle after the accepted start and stays high up to the cycle before done_o or trap_o. Each of these pulses lasts one cycle with busy_o low. A start_i pulse while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an instruction (taken only when idle) |
| vlen_i | input | IDX_W | Number of elements in the instruction |
| base_i | input | ADDR_W | Address of element 0 |
| stride_i | input | ADDR_W | Byte distance between elements |
| xlat_req_o | output | 1 | Translation request for the current element |
| xlat_idx_o | output | IDX_W | Index of the current element |
| xlat_addr_o | output | ADDR_W | Address of the current element |
| xlat_rsp_valid_i | input | 1 | Translation answer is present |
| xlat_fault_i | input | 1 | Answer is a page fault (with xlat_rsp_valid_i) |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle pulse: all elements finished |
| trap_o | output | 1 | One-cycle pulse: page fault taken |
| trap_idx_o | output | IDX_W | Faulting element index, valid with trap_o |
| trap_addr_o | output | ADDR_W | Faulting element address, valid with trap_o |
| csr_we_i | input | 1 | Write the progress register |
| csr_wdata_i | input | IDX_W | Value to write |
| csr_rdata_o | output | IDX_W | Current progress register value |

## Verification
The hardest situation to reach from the ports is a resumed instruction whose starting index comes from a trap rather than from software. It must skip the lower elements and still produce the right addresses, and a CSR write or a second start that arrives while that instruction runs must be refused. The bench gets there by running a faulting instruction, then restarting the same instruction without touching the CSR. It repeats this with the fault at the first element, the middle and the last, with varied response latency and an address that wraps. It also fires CSR writes and extra start pulses in the middle of runs. A behavioural model that recomputes each expected address from index times stride is compared with the outputs on every cycle.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } sq_state_e;

endpackage

// File: rtl/vseq_progress.sv
// Element-progress register: captures the faulting element, clears on
// completion, and accepts software writes only when the controller allows.
module vseq_progress #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_val_i,
    input  logic             set_en_i,
    input  logic [IDX_W-1:0] set_val_i,
    input  logic             clr_en_i,
    output logic [IDX_W-1:0] val_o
);

    typedef struct packed {
        logic [IDX_W-1:0] val;
    } prog_reg_t;

    prog_reg_t prog_d, prog_q;

    always_comb begin
        prog_d = prog_q;
        if (clr_en_i) begin
            prog_d.val = '0;
        end else if (set_en_i) begin
            prog_d.val = set_val_i;
        end else if (wr_en_i) begin
            prog_d.val = wr_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_q <= '0;
        end else begin
            prog_q <= prog_d;
        end
    end

    assign val_o = prog_q.val;

endmodule

// File: rtl/vseq_addr_step.sv
// Element address generator: a full base + index*stride product on load,
// a single stride addition when stepping.
module vseq_addr_step #(
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 32
) (
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [IDX_W-1:0]  first_idx_i,
    input  logic [ADDR_W-1:0] cur_addr_i,
    output logic [ADDR_W-1:0] next_addr_o
);

    logic [ADDR_W-1:0] idx_ext;
    logic [ADDR_W-1:0] offset;

    generate
        if (ADDR_W > IDX_W) begin : g_zext
            assign idx_ext = {{(ADDR_W-IDX_W){1'b0}}, first_idx_i};
        end else begin : g_trunc
            assign idx_ext = first_idx_i[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        offset = idx_ext * stride_i;
        if (load_i) begin
            next_addr_o = base_i + offset;
        end else begin
            next_addr_o = cur_addr_i + stride_i;
        end
    end

endmodule

// File: rtl/vseq_ctrl.sv
// Sequencing controller: issue, wait for translation, trap or finish.
module vseq_ctrl
    import vseq_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  vlen_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [IDX_W-1:0]  prog_i,
    input  logic              rsp_valid_i,
    input  logic              rsp_fault_i,
    input  logic [ADDR_W-1:0] addr_next_i,
    output logic              addr_load_o,
    output logic [ADDR_W-1:0] addr_stride_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic              req_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              idle_o,
    output logic              done_o,
    output logic              trap_o,
    output logic [IDX_W-1:0]  trap_idx_o,
    output logic [ADDR_W-1:0] trap_addr_o,
    output logic              prog_set_o,
    output logic              prog_clr_o
);

    typedef struct packed {
        sq_state_e         state;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  vlen;
        logic [ADDR_W-1:0] stride;
        logic [ADDR_W-1:0] addr;
        logic              done;
        logic              trap;
        logic [IDX_W-1:0]  tidx;
        logic [ADDR_W-1:0] taddr;
    } ctrl_reg_t;

    ctrl_reg_t ctl_d, ctl_q;
    logic      all_issued;

    assign all_issued = (ctl_q.idx >= ctl_q.vlen);

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.done    = 1'b0;
        ctl_d.trap    = 1'b0;
        addr_load_o   = 1'b0;
        prog_set_o    = 1'b0;
        prog_clr_o    = 1'b0;
        addr_stride_o = ctl_q.stride;

        unique case (ctl_q.state)
            SQ_IDLE: begin
                if (start_i) begin
                    addr_load_o   = 1'b1;
                    addr_stride_o = stride_i;
                    ctl_d.state   = SQ_ISSUE;
                    ctl_d.idx     = prog_i;
                    ctl_d.vlen    = vlen_i;
                    ctl_d.stride  = stride_i;
                    ctl_d.addr    = addr_next_i;
                end
            end
            SQ_ISSUE: begin
                if (all_issued) begin
                    ctl_d.state = SQ_IDLE;
                    ctl_d.done  = 1'b1;
                    prog_clr_o  = 1'b1;
                end else begin
                    ctl_d.state = SQ_WAIT;
                end
            end
            SQ_WAIT: begin
                if (rsp_valid_i) begin
                    if (rsp_fault_i) begin
                        ctl_d.state = SQ_IDLE;
                        ctl_d.trap  = 1'b1;
                        ctl_d.tidx  = ctl_q.idx;
                        ctl_d.taddr = ctl_q.addr;
                        prog_set_o  = 1'b1;
                    end else begin
                        ctl_d.state = SQ_ISSUE;
                        ctl_d.idx   = ctl_q.idx + 1'b1;
                        ctl_d.addr  = addr_next_i;
                    end
                end
            end
            default: begin
                ctl_d.state = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= SQ_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cur_addr_o  = ctl_q.addr;
    assign req_o       = (ctl_q.state == SQ_ISSUE) && !all_issued;
    assign idx_o       = ctl_q.idx;
    assign idle_o      = (ctl_q.state == SQ_IDLE);
    assign done_o      = ctl_q.done;
    assign trap_o      = ctl_q.trap;
    assign trap_idx_o  = ctl_q.tidx;
    assign trap_addr_o = ctl_q.taddr;

endmodule

// File: rtl/vec_restart_seq.sv
module vec_restart_seq #(
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  vlen_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    output logic              xlat_req_o,
    output logic [IDX_W-1:0]  xlat_idx_o,
    output logic [ADDR_W-1:0] xlat_addr_o,
    input  logic              xlat_rsp_valid_i,
    input  logic              xlat_fault_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              trap_o,
    output logic [IDX_W-1:0]  trap_idx_o,
    output logic [ADDR_W-1:0] trap_addr_o,
    input  logic              csr_we_i,
    input  logic [IDX_W-1:0]  csr_wdata_i,
    output logic [IDX_W-1:0]  csr_rdata_o
);

    logic              addr_load;
    logic [ADDR_W-1:0] addr_stride;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] addr_next;
    logic [IDX_W-1:0]  prog_val;
    logic              idle;
    logic              prog_set;
    logic              prog_clr;
    logic              csr_wr_ok;
    logic [IDX_W-1:0]  cur_idx;

    vseq_ctrl #(
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .vlen_i        (vlen_i),
        .stride_i      (stride_i),
        .prog_i        (prog_val),
        .rsp_valid_i   (xlat_rsp_valid_i),
        .rsp_fault_i   (xlat_fault_i),
        .addr_next_i   (addr_next),
        .addr_load_o   (addr_load),
        .addr_stride_o (addr_stride),
        .cur_addr_o    (cur_addr),
        .req_o         (xlat_req_o),
        .idx_o         (cur_idx),
        .idle_o        (idle),
        .done_o        (done_o),
        .trap_o        (trap_o),
        .trap_idx_o    (trap_idx_o),
        .trap_addr_o   (trap_addr_o),
        .prog_set_o    (prog_set),
        .prog_clr_o    (prog_clr)
    );

    vseq_addr_step #(
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .load_i      (addr_load),
        .base_i      (base_i),
        .stride_i    (addr_stride),
        .first_idx_i (prog_val),
        .cur_addr_i  (cur_addr),
        .next_addr_o (addr_next)
    );

    assign csr_wr_ok = csr_we_i && idle && !start_i;

    vseq_progress #(
        .IDX_W (IDX_W)
    ) u_prog (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (csr_wr_ok),
        .wr_val_i  (csr_wdata_i),
        .set_en_i  (prog_set),
        .set_val_i (cur_idx),
        .clr_en_i  (prog_clr),
        .val_o     (prog_val)
    );

    assign busy_o      = !idle;
    assign xlat_idx_o  = cur_idx;
    assign xlat_addr_o = cur_addr;
    assign csr_rdata_o = prog_val;

endmodule

// File: rtl/vseq_checker.sv
module vseq_checker #(
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              xlat_req_o,
    input logic [IDX_W-1:0]  xlat_idx_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              trap_o,
    input logic [IDX_W-1:0]  trap_idx_o,
    input logic              csr_we_i,
    input logic [IDX_W-1:0]  csr_rdata_o
);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_trap_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> !trap_o);

    p_end_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || trap_o) |-> !busy_o);

    p_req_in_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_req_o |-> busy_o);

    p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_req_o |=> !xlat_req_o);

    p_trap_records_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (csr_rdata_o == trap_idx_o));

    p_trap_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> !xlat_req_o);

    p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (csr_rdata_o == '0));

    p_start_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (xlat_idx_o == $past(csr_rdata_o)));

    p_csr_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(csr_rdata_o) |->
            (done_o || trap_o || $past(csr_we_i && !busy_o && !start_i)));

endmodule

bind vec_restart_seq vseq_checker #(
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .xlat_req_o  (xlat_req_o),
    .xlat_idx_o  (xlat_idx_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .trap_o      (trap_o),
    .trap_idx_o  (trap_idx_o),
    .csr_we_i    (csr_we_i),
    .csr_rdata_o (csr_rdata_o)
);

// File: tb/sim_vec_restart_seq.sv
`timescale 1ns/1ps
module sim_vec_restart_seq;

    localparam int IDX_W  = 8;
    localparam int ADDR_W = 32;
    localparam int WATCHDOG_CYC = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [IDX_W-1:0]  vlen_i = '0;
    logic [ADDR_W-1:0] base_i = '0;
    logic [ADDR_W-1:0] stride_i = '0;
    logic              xlat_req_o;
    logic [IDX_W-1:0]  xlat_idx_o;
    logic [ADDR_W-1:0] xlat_addr_o;
    logic              xlat_rsp_valid_i = 1'b0;
    logic              xlat_fault_i = 1'b0;
    logic              busy_o, done_o, trap_o;
    logic [IDX_W-1:0]  trap_idx_o;
    logic [ADDR_W-1:0] trap_addr_o;
    logic              csr_we_i = 1'b0;
    logic [IDX_W-1:0]  csr_wdata_i = '0;
    logic [IDX_W-1:0]  csr_rdata_o;

    always #10 clk = ~clk;

    vec_restart_seq #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u0 (.*);

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---- behavioural reference model (0 idle, 1 issue, 2 wait) ----
    int              m_state = 0;
    int              m_idx = 0, m_vlen = 0, m_prog = 0, m_tidx = 0;
    logic [ADDR_W-1:0] m_base = '0, m_stride = '0, m_taddr = '0;
    bit              m_done = 0, m_trap = 0;

    function automatic logic [ADDR_W-1:0] elem_addr(input int i);
        logic [ADDR_W-1:0] ii;
        ii = ADDR_W'(i);
        return m_base + ii * m_stride;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_prog = 0; m_done = 0; m_trap = 0;
        end else begin
            m_done = 0; m_trap = 0;
            case (m_state)
                0: begin
                    if (start_i) begin
                        m_vlen = int'(vlen_i); m_base = base_i; m_stride = stride_i;
                        m_idx = m_prog; m_state = 1;
                    end else if (csr_we_i) begin
                        m_prog = int'(csr_wdata_i);
                    end
                end
                1: begin
                    if (m_idx >= m_vlen) begin
                        m_prog = 0; m_done = 1; m_state = 0;
                    end else m_state = 2;
                end
                default: begin
                    if (xlat_rsp_valid_i) begin
                        if (xlat_fault_i) begin
                            m_prog = m_idx; m_trap = 1; m_tidx = m_idx;
                            m_taddr = elem_addr(m_idx); m_state = 0;
                        end else begin
                            m_idx++; m_state = 1;
                        end
                    end
                end
            endcase
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_req;
            exp_req = (m_state == 1) && (m_idx < m_vlen);
            check(busy_o == (m_state != 0), "R10 busy", busy_o, m_state != 0);
            check(xlat_req_o == exp_req, "R4 request", xlat_req_o, exp_req);
            if (exp_req) begin
                check(int'(xlat_idx_o) == m_idx, "R3 index", xlat_idx_o, m_idx);
                check(xlat_addr_o == elem_addr(m_idx), "R3 address", xlat_addr_o, elem_addr(m_idx));
            end
            check(done_o == m_done, "R7 done", done_o, m_done);
            check(trap_o == m_trap, "R5 trap", trap_o, m_trap);
            if (m_trap) begin
                check(int'(trap_idx_o) == m_tidx, "R5 trap index", trap_idx_o, m_tidx);
                check(trap_addr_o == m_taddr, "R5 trap address", trap_addr_o, m_taddr);
            end
            check(int'(csr_rdata_o) == m_prog, "R9 csr read", csr_rdata_o, m_prog);
        end
    end

    // ---- translation responder and request monitor ----
    int fault_at = -1;
    int lat = 1;
    int pend = 0, pend_idx = 0;
    int n_req = 0, first_idx = -1, min_idx = 1 << 30;

    always @(negedge clk) begin
        xlat_rsp_valid_i = 1'b0;
        xlat_fault_i = 1'b0;
        if (pend == 1) begin
            xlat_rsp_valid_i = 1'b1;
            xlat_fault_i = (pend_idx == fault_at);
            pend = 0;
        end else if (pend > 1) begin
            pend--;
        end
        if (xlat_req_o) begin
            pend = lat;
            pend_idx = int'(xlat_idx_o);
            n_req++;
            if (first_idx < 0) first_idx = int'(xlat_idx_o);
            if (int'(xlat_idx_o) < min_idx) min_idx = int'(xlat_idx_o);
        end
    end

    task automatic csr_write(input int v);
        @(negedge clk); csr_we_i = 1'b1; csr_wdata_i = IDX_W'(v);
        @(negedge clk); csr_we_i = 1'b0;
    endtask

    // run one instruction; returns 1 on trap, 0 on done
    task automatic run(input int vl, input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] s,
                       input int f_at, input int l, output bit trapped);
        fault_at = f_at; lat = l;
        n_req = 0; first_idx = -1; min_idx = 1 << 30;
        @(negedge clk);
        vlen_i = IDX_W'(vl); base_i = b; stride_i = s; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        trapped = 0;
        for (int k = 0; k < 5000; k++) begin
            if (done_o || trap_o) break;
            @(negedge clk);
        end
        trapped = trap_o;
    endtask

    initial begin
        #(20.0 * WATCHDOG_CYC);
        fails++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit t;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy_o && !done_o && !trap_o && !xlat_req_o, "R1 reset outputs",
              {busy_o, done_o, trap_o, xlat_req_o}, 0);
        check(csr_rdata_o == 0, "R1 reset progress", csr_rdata_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7 clean run from zero
        run(5, 32'h1000, 32'h8, -1, 1, t);
        check(!t && n_req == 5, "R7 full run count", n_req, 5);
        check(csr_rdata_o == 0, "R7 progress cleared", csr_rdata_o, 0);

        // R5 fault in the middle, then R6 resume
        run(8, 32'h2000, 32'h4, 3, 2, t);
        check(t && trap_idx_o == 3, "R5 trap at 3", trap_idx_o, 3);
        check(csr_rdata_o == 3, "R5 progress holds 3", csr_rdata_o, 3);
        run(8, 32'h2000, 32'h4, -1, 1, t);
        check(first_idx == 3 && min_idx == 3, "R6 resume index", first_idx, 3);
        check(!t && n_req == 5, "R6 remaining count", n_req, 5);
        // R7 next instruction begins at 0
        run(2, 32'h0, 32'h10, -1, 1, t);
        check(first_idx == 0, "R7 restart at zero", first_idx, 0);

        // R8 progress beyond length
        csr_write(4);
        check(csr_rdata_o == 4, "R9 idle write", csr_rdata_o, 4);
        run(4, 32'h0, 32'h1, -1, 1, t);
        check(!t && n_req == 0, "R8 no requests", n_req, 0);
        check(csr_rdata_o == 0, "R8 progress cleared", csr_rdata_o, 0);

        // R2 start from a written index, with wrap-around addresses
        csr_write(2);
        run(6, 32'hFFFF_FFF0, 32'h10, -1, 3, t);
        check(first_idx == 2 && n_req == 4, "R2 start at written index", first_idx, 2);

        // R9 write during a run ignored; R10 extra start ignored
        fault_at = 5; lat = 4;
        n_req = 0;
        @(negedge clk);
        vlen_i = 8'd9; base_i = 32'h40; stride_i = 32'hFFFF_FFFC; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (3) @(negedge clk);
        csr_we_i = 1'b1; csr_wdata_i = 8'd7; start_i = 1'b1;
        @(negedge clk); csr_we_i = 1'b0; start_i = 1'b0;
        for (int k = 0; k < 500; k++) begin
            if (done_o || trap_o) break;
            @(negedge clk);
        end
        check(trap_o && csr_rdata_o == 5, "R9 busy write ignored", csr_rdata_o, 5);
        check(n_req == 6, "R10 extra start ignored", n_req, 6);

        // R5 fault on the very first element of the resume
        run(9, 32'h40, 32'hFFFF_FFFC, 5, 1, t);
        check(t && trap_idx_o == 5 && n_req == 1, "R5 fault on first issued", trap_idx_o, 5);
        // R5 fault on last element
        run(9, 32'h40, 32'hFFFF_FFFC, 8, 2, t);
        check(t && trap_idx_o == 8, "R5 fault on last", trap_idx_o, 8);
        run(9, 32'h40, 32'hFFFF_FFFC, -1, 1, t);
        check(!t && n_req == 1 && csr_rdata_o == 0, "R7 finish after last fault", n_req, 1);

        // R9 write and start in the same idle cycle: write refused
        @(negedge clk);
        csr_we_i = 1'b1; csr_wdata_i = 8'd1; vlen_i = 8'd2; start_i = 1'b1; fault_at = -1; lat = 1;
        @(negedge clk); csr_we_i = 1'b0; start_i = 1'b0;
        for (int k = 0; k < 100; k++) begin
            if (done_o || trap_o) break;
            @(negedge clk);
        end
        check(done_o && csr_rdata_o == 0, "R9 write with start refused", csr_rdata_o, 0);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule